// File: doc/BRIEF.md
# Byte-Serial Four-Value Sorter

This block takes four unsigned 8-bit values, one per transfer on a valid/ready input stream, and holds them in a four-slot buffer. Once the buffer is full, a fixed network of five compare-exchange cells puts them in ascending order. The cells are arranged in three registered layers, and the cells within a layer act side by side. The ordered values then leave on a valid/ready output stream, smallest first, one per transfer. After that the block is ready for the next group of four.

A controller moves through three phases: fill, sort and drain. Input back-pressure is simple. `in_ready` is high only in the fill phase, and a value is taken only on a cycle where both `in_valid` and `in_ready` are high. Anything offered at other times is left untaken and has no effect. Output back-pressure works the same way. The source may raise `in_valid` without waiting for `in_ready`. `out_valid` stays high through the drain phase, and `out_data` holds steady until the sink raises `out_ready`. The plain `busy` flag is high during the sort and drain phases.

Top module: `quad_sort_stream`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it falls, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: In the fill phase `in_ready` is 1. A value is stored on each rising edge where `in_valid` and `in_ready` are both high. Stored values occupy slots 0, 1, 2 and 3 in arrival order.
- R3: From the cycle after the fourth value is taken until the last output transfer completes, `in_ready` is 0 and `busy` is 1.
- R4: The sort takes three cycles. `out_valid` first goes high in the fourth cycle after the edge that took the fourth value.
- R5: The four output transfers carry the values in ascending unsigned order, smallest first. An ordering based on a signed comparison would put 128 and 255 before 0, and that is wrong.
- R6: Equal values are never swapped or dropped. The output is exactly the multiset of inputs, duplicates included.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R8: Values offered while `busy` is 1 are ignored. The next group's result holds only values taken during its fill phase.
- R9: In the cycle after the fourth output transfer, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R10: A synchronous reset in the middle of a fill discards the partial group. The next four values taken form a complete group by themselves.
- R11: Idle cycles in the fill phase, where `in_valid` is 0, store nothing and do not advance the fill position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block can take a value (fill phase) |
| in_data | input | 8 | Unsigned input value |
| out_valid | output | 1 | Sorted value offered (drain phase) |
| out_ready | input | 1 | Sink takes the offered value |
| out_data | output | 8 | Sorted output value, ascending order |
| busy | output | 1 | Sort or drain in progress |

## Verification
Two events can land in the same cycle: the final output transfer that ends the drain, and a new input value that the source is already offering. The bench holds `in_valid` high with junk data through the whole sort and drain, so the final drain handshake meets an offered input. The bench then checks that `in_ready` was still low on that edge and that the junk never appears in the next group's sorted output. A sweep over every four-value pattern drawn from a five-value set includes equal values and values with the top bit set. The expected order is computed arithmetically in the bench, under both pseudo-random output stalls and input gaps.

// File: rtl/qsort_pkg.sv
package qsort_pkg;
  localparam int unsigned ELEM_W  = 8;
  localparam int unsigned N_ELEM  = 4;
  localparam int unsigned N_LAYER = 3;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_SORT  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/cx_cell.sv
module cx_cell #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;

  // exchange only on strict less-than, so equal values stay put
  always_comb begin
    swap = (b < a);
    lo   = swap ? b : a;
    hi   = swap ? a : b;
  end

  // R5: lower output never exceeds the upper one, and no value is lost (R6)
  always_comb begin
    a_cx_order_r5: assert (lo <= hi);
    a_cx_keep_r6:  assert ((lo == a && hi == b) || (lo == b && hi == a));
  end
endmodule

// File: rtl/sort_layer.sv
module sort_layer #(
  parameter int unsigned W     = 8,
  parameter int unsigned N     = 4,
  parameter int unsigned LAYER = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [N-1:0][W-1:0] d,
  output logic [N-1:0][W-1:0] q
);
  logic [N-1:0][W-1:0] nxt;

  generate
    if (LAYER == 0) begin : g_l0
      cx_cell #(.W(W)) u_c01 (.a(d[0]), .b(d[1]), .lo(nxt[0]), .hi(nxt[1]));
      cx_cell #(.W(W)) u_c23 (.a(d[2]), .b(d[3]), .lo(nxt[2]), .hi(nxt[3]));
    end else if (LAYER == 1) begin : g_l1
      cx_cell #(.W(W)) u_c02 (.a(d[0]), .b(d[2]), .lo(nxt[0]), .hi(nxt[2]));
      cx_cell #(.W(W)) u_c13 (.a(d[1]), .b(d[3]), .lo(nxt[1]), .hi(nxt[3]));
    end else begin : g_l2
      assign nxt[0] = d[0];
      assign nxt[3] = d[3];
      cx_cell #(.W(W)) u_c12 (.a(d[1]), .b(d[2]), .lo(nxt[1]), .hi(nxt[2]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/sort_net.sv
module sort_net #(
  parameter int unsigned W      = 8,
  parameter int unsigned N      = 4,
  parameter int unsigned LAYERS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N-1:0][W-1:0] unsorted,
  output logic [N-1:0][W-1:0] sorted,
  output logic                done
);
  logic [LAYERS:0][N-1:0][W-1:0] lane;
  logic [LAYERS:0]               stg_en;

  assign lane[0]   = unsorted;
  assign stg_en[0] = start;

  genvar s;
  generate
    for (s = 0; s < LAYERS; s++) begin : g_layer
      sort_layer #(.W(W), .N(N), .LAYER(s)) u_layer (
        .clk (clk),
        .rst (rst),
        .en  (stg_en[s]),
        .d   (lane[s]),
        .q   (lane[s+1])
      );
      always_ff @(posedge clk) begin
        if (rst) stg_en[s+1] <= 1'b0;
        else     stg_en[s+1] <= stg_en[s];
      end
    end
  endgenerate

  assign sorted = lane[LAYERS];
  assign done   = stg_en[LAYERS];

  // R5: when the last layer has captured, the result is ascending
  p_net_order_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (sorted[0] <= sorted[1] && sorted[1] <= sorted[2] && sorted[2] <= sorted[3]));
  // R4: the last layer finishes exactly LAYERS-1 cycles after the first one took its input
  p_net_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(stg_en[1], 2));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import qsort_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned N      = 4,
  parameter int unsigned LAYERS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [W-1:0]        in_data,
  input  logic                out_ready,
  output logic                in_ready,
  output logic                out_valid,
  output logic                start,
  output logic [N-1:0][W-1:0] slots,
  output logic [$clog2(N)-1:0] rd_idx,
  output phase_e              phase
);
  localparam int unsigned CW = $clog2(N);
  localparam int unsigned SW = $clog2(LAYERS);
  localparam logic [CW-1:0] LAST_SLOT  = CW'(N - 1);
  localparam logic [SW-1:0] LAST_LAYER = SW'(LAYERS - 1);

  logic [CW-1:0] fill_idx;
  logic [SW-1:0] step;
  logic          take_in, give_out;

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign take_in   = in_valid && in_ready;
  assign give_out  = out_valid && out_ready;
  assign start     = (phase == PH_SORT) && (step == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FILL;
      fill_idx <= '0;
      step     <= '0;
      rd_idx   <= '0;
      slots    <= '0;
    end else begin
      unique case (phase)
        PH_FILL: begin
          if (take_in) begin
            slots[fill_idx] <= in_data;
            if (fill_idx == LAST_SLOT) begin
              fill_idx <= '0;
              step     <= '0;
              phase    <= PH_SORT;
            end else begin
              fill_idx <= fill_idx + 1'b1;
            end
          end
        end
        PH_SORT: begin
          if (step == LAST_LAYER) begin
            step   <= '0;
            rd_idx <= '0;
            phase  <= PH_DRAIN;
          end else begin
            step <= step + 1'b1;
          end
        end
        PH_DRAIN: begin
          if (give_out) begin
            if (rd_idx == LAST_SLOT) begin
              rd_idx <= '0;
              phase  <= PH_FILL;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        default: phase <= PH_FILL;
      endcase
    end
  end

  // R3: once the fourth value is in, the input side stays closed next cycle
  p_close_after_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (take_in && fill_idx == LAST_SLOT) |=> !in_ready);
  // R8: nothing is stored while not filling
  p_slots_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_FILL) |=> $stable(slots));
  // R11: an idle fill cycle leaves the fill position unchanged
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL && !in_valid) |=> $stable(fill_idx));
  // R9: after the last output transfer the block is back to filling
  p_refill_r9: assert property (@(posedge clk) disable iff (rst)
    (give_out && rd_idx == LAST_SLOT) |=> (in_ready && !out_valid));
endmodule

// File: rtl/quad_sort_stream.sv
module quad_sort_stream
  import qsort_pkg::*;
#(
  parameter int unsigned W      = ELEM_W,
  parameter int unsigned N      = N_ELEM,
  parameter int unsigned LAYERS = N_LAYER
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         busy
);
  localparam int unsigned CW = $clog2(N);

  logic [N-1:0][W-1:0] slots;
  logic [N-1:0][W-1:0] sorted;
  logic [CW-1:0]       rd_idx;
  logic                start, done;
  phase_e              phase;

  seq_ctrl #(.W(W), .N(N), .LAYERS(LAYERS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .start     (start),
    .slots     (slots),
    .rd_idx    (rd_idx),
    .phase     (phase)
  );

  sort_net #(.W(W), .N(N), .LAYERS(LAYERS)) u_net (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .unsorted (slots),
    .sorted   (sorted),
    .done     (done)
  );

  assign out_data = sorted[rd_idx];
  assign busy     = (phase != PH_FILL);

  // R4: the network result lands exactly as the drain phase begins
  p_done_meets_drain_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && $rose(out_valid)));
  // R4: output opens four edges after the edge that took the last input
  p_drain_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready, 4));
  // R7: a stalled output holds its value
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R3: busy and input readiness are never high together
  p_busy_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(busy && in_ready));
endmodule

// File: tb/quad_sort_stream_test.sv
module quad_sort_stream_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       busy;

  int   n_cmp = 0;
  int   n_bad = 0;
  logic [7:0] lfsr = 8'h5A;
  logic       finished = 1'b0;

  always #4 clk = ~clk;

  quad_sort_stream uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0][7:0] ref_sort(input logic [3:0][7:0] v);
    logic [3:0][7:0] r = v;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (r[j] > r[j+1]) begin
          logic [7:0] t = r[j];
          r[j] = r[j+1];
          r[j+1] = t;
        end
    return r;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  // fill with optional idle gaps, then drain under pseudo-random stalls
  task automatic run_group(input logic [3:0][7:0] v, input int gap);
    logic [3:0][7:0] e = ref_sort(v);
    bit dup = (e[0] == e[1]) || (e[1] == e[2]) || (e[2] == e[3]);
    int j = 0;
    for (int i = 0; i < 4; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hA5;          // R11: idle cycle, data must be ignored
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 in_ready during fill", in_ready, 1);
      in_valid = 1'b1;
      in_data  = v[i];
      @(posedge clk);
    end
    // sort phase, junk offered all along (R8)
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(k * 37 + 3);
      if (k == 1) begin
        chk(busy == 1'b1, "R3 busy after fill", busy, 1);
        chk(in_ready == 1'b0, "R3 in_ready after fill", in_ready, 0);
      end
      chk(out_valid == (k == 4), "R4 drain latency", out_valid, int'(k == 4));
    end
    while (j < 4) begin
      logic [7:0] held = out_data;
      bit rdy;
      step_lfsr();
      rdy = lfsr[0] | lfsr[1];
      out_ready = rdy;
      in_data   = 8'(in_data + 8'd91);
      if (rdy) begin
        if (dup) chk(out_data == e[j], "R6 duplicate order", out_data, e[j]);
        else     chk(out_data == e[j], "R5 ascending order", out_data, e[j]);
        j++;
      end
      @(negedge clk);
      if (!rdy) chk(out_valid && out_data == held, "R7 stall hold", out_data, held);
      else if (j < 4) chk(busy && !in_ready, "R3 closed during drain", in_ready, 0);
    end
    out_ready = 1'b0;
    chk(in_ready && !busy && !out_valid, "R9 back to fill", {in_ready, busy, out_valid}, 4);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [5];
    pool[0] = 8'd0; pool[1] = 8'd1; pool[2] = 8'd7; pool[3] = 8'd128; pool[4] = 8'd255;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !busy, "R1 during reset", {in_ready, out_valid, busy}, 4);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid && !busy, "R1 after reset", {in_ready, out_valid, busy}, 4);

    // R10: partial group then reset, partial values must not survive
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'd200 + 8'(i);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready && !busy, "R10 fill reopened", in_ready, 1);
    run_group({8'd4, 8'd3, 8'd2, 8'd1}, 0);   // R10: only these four may appear

    // near-exhaustive sweep over all patterns from the pool
    for (int idx = 0; idx < 625; idx++) begin
      logic [3:0][7:0] v;
      v[0] = pool[idx % 5];
      v[1] = pool[(idx / 5) % 5];
      v[2] = pool[(idx / 25) % 5];
      v[3] = pool[(idx / 125) % 5];
      run_group(v, (idx % 3 == 0) ? 2 : 0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule